// File: doc/BRIEF.md
# Threshold-Driven FIFO Service Interrupt

This block is a 16-entry, byte-wide FIFO that sits between a host that moves data by programmed I/O and a byte stream on the peripheral side. A direction input sets the flow. In forward mode the host writes and the peripheral reads. In reverse mode the peripheral writes and the host reads. The strobes of the side that is not active have no effect.

The host sets a 4-bit threshold. The block raises a level service interrupt when the host has enough work for one burst, provided the service mask is clear:

- **Forward:** at least (16 − threshold) bytes are free, which is the same as a byte count at or below the threshold.
- **Reverse:** at least (16 − threshold) bytes are held.

Full and empty flags let the host size its burst. When it sees empty in forward mode or full in reverse mode, it can move all 16 bytes. Otherwise it can move at least 16 − threshold bytes. It keeps answering requests until the last byte has gone.

A write to a full FIFO or a read from an empty one is dropped and sets a sticky error flag. The flag stays set until a clear strobe.

Top module: `fifo_svc_irq`

## Requirements
- R1: Bytes leave in the order they were accepted, and `rd_data_o` shows the oldest held byte without latency (first-word fall-through).
- R2: When `dir_i`=0 (forward), pushes come from `host_wr_i` and pops from `per_rd_i`. When `dir_i`=1 (reverse), pushes come from `per_wr_i` and pops from `host_rd_i`. Strobes of the inactive side change neither the count nor the error flag.
- R3: `count_o` tracks the held bytes from 0 to 16, one clock after each accepted strobe. `empty_o` is 1 exactly when the count is 0, and `full_o` is 1 exactly when the count is 16.
- R4: In forward mode with the mask clear, `irq_o` is 1 exactly when the count is at or below `thresh_i`.
- R5: In reverse mode with the mask clear, `irq_o` is 1 exactly when the count plus `thresh_i` is at least 16.
- R6: While `svc_mask_i` is 1, `irq_o` is 0.
- R7: A push while full or a pop while empty is dropped, leaves the stored data intact and sets `err_o` on the next clock.
- R8: A push and a pop accepted in the same cycle leave the count unchanged and keep the data in order.
- R9: `err_o` stays at 1 until a cycle with `err_clr_i`=1. If a new illegal access arrives in that same cycle, the flag stays set.
- R10: After reset the count is 0, `empty_o`=1, `full_o`=0 and `err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | 0 forward (host to peripheral), 1 reverse |
| thresh_i | input | 4 | Service threshold |
| svc_mask_i | input | 1 | 1 masks the service interrupt |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 8 | Host write byte |
| host_rd_i | input | 1 | Host read strobe |
| per_wr_i | input | 1 | Peripheral write strobe |
| per_wdata_i | input | 8 | Peripheral write byte |
| per_rd_i | input | 1 | Peripheral read strobe |
| rd_data_o | output | 8 | Oldest held byte |
| count_o | output | 5 | Held byte count |
| full_o | output | 1 | 16 bytes held |
| empty_o | output | 1 | No byte held |
| irq_o | output | 1 | Service interrupt level |
| err_o | output | 1 | Sticky illegal access flag |
| err_clr_i | input | 1 | Clears the error flag |

## Verification
The assertions assume that `dir_i` selects which strobes count, and they derive the accepted push and pop from the ports and flags alone. They also assume that the threshold and mask can change in any cycle, since the interrupt is a combinational level. The bench changes direction only while the FIFO is idle, so the scoreboard queue remains a single ordered stream. It drives deliberate overflow, underflow and inactive-side strobes so that the dropped accesses and the error flag are exercised on purpose rather than by accident.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } dir_e;
endpackage

// File: rtl/fsi_store.sv
module fsi_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_ptr_q, rd_ptr_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_ptr_q];
endmodule

// File: rtl/fsi_level.sv
module fsi_level #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_req_i,
  input  logic          pop_req_i,
  input  logic          err_clr_i,
  output logic          push_ok_o,
  output logic          pop_ok_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          err_o
);
  logic [CW-1:0] cnt_q;
  logic          err_q;
  logic          illegal;

  assign full_o    = (cnt_q == CW'(DEPTH));
  assign empty_o   = (cnt_q == '0);
  assign push_ok_o = push_req_i && !full_o;
  assign pop_ok_o  = pop_req_i && !empty_o;
  assign illegal   = (push_req_i && full_o) || (pop_req_i && empty_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (push_ok_o && !pop_ok_o)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok_o && !push_ok_o) cnt_q <= cnt_q - 1'b1;
      // new error wins over clear
      if (illegal)        err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
    end
  end

  assign count_o = cnt_q;
  assign err_o   = err_q;
endmodule

// File: rtl/fsi_irq.sv
module fsi_irq #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned TW   = $clog2(DEPTH)
) (
  input  fsi_pkg::dir_e dir_i,
  input  logic [TW-1:0] thresh_i,
  input  logic          mask_i,
  input  logic [CW-1:0] count_i,
  output logic          irq_o
);
  logic [CW:0] sum;
  logic        fwd_hit, rev_hit;

  assign fwd_hit = (CW'(thresh_i) >= count_i);
  assign sum     = (CW+1)'(count_i) + (CW+1)'(thresh_i);
  assign rev_hit = (sum >= (CW+1)'(DEPTH));

  always_comb begin
    irq_o = 1'b0;
    if (!mask_i) irq_o = (dir_i == fsi_pkg::DIR_REV) ? rev_hit : fwd_hit;
  end
endmodule

// File: rtl/fifo_svc_irq.sv
module fifo_svc_irq #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned TW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_i,
  input  logic [TW-1:0]    thresh_i,
  input  logic             svc_mask_i,
  input  logic             host_wr_i,
  input  logic [WIDTH-1:0] host_wdata_i,
  input  logic             host_rd_i,
  input  logic             per_wr_i,
  input  logic [WIDTH-1:0] per_wdata_i,
  input  logic             per_rd_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             irq_o,
  output logic             err_o,
  input  logic             err_clr_i
);
  fsi_pkg::dir_e    dir;
  logic             push_req, pop_req, push_ok, pop_ok;
  logic [WIDTH-1:0] wdata;

  assign dir      = fsi_pkg::dir_e'(dir_i);
  assign push_req = (dir == fsi_pkg::DIR_REV) ? per_wr_i : host_wr_i;
  assign pop_req  = (dir == fsi_pkg::DIR_REV) ? host_rd_i : per_rd_i;
  assign wdata    = (dir == fsi_pkg::DIR_REV) ? per_wdata_i : host_wdata_i;

  fsi_level #(.DEPTH(DEPTH)) u_level (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_req_i(push_req), .pop_req_i(pop_req), .err_clr_i(err_clr_i),
    .push_ok_o(push_ok), .pop_ok_o(pop_ok),
    .count_o(count_o), .full_o(full_o), .empty_o(empty_o), .err_o(err_o)
  );

  fsi_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(push_ok), .pop_i(pop_ok),
    .wdata_i(wdata), .rdata_o(rd_data_o)
  );

  fsi_irq #(.DEPTH(DEPTH)) u_irq (
    .dir_i(dir), .thresh_i(thresh_i), .mask_i(svc_mask_i),
    .count_i(count_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/fsi_checker.sv
module fsi_checker #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dir_i,
  input logic          svc_mask_i,
  input logic          host_wr_i,
  input logic          host_rd_i,
  input logic          per_wr_i,
  input logic          per_rd_i,
  input logic [CW-1:0] count_o,
  input logic          full_o,
  input logic          empty_o,
  input logic          irq_o,
  input logic          err_o,
  input logic          err_clr_i
);
  logic push_r, pop_r, bad_acc;
  assign push_r  = dir_i ? per_wr_i : host_wr_i;
  assign pop_r   = dir_i ? host_rd_i : per_rd_i;
  assign bad_acc = (push_r && full_o) || (pop_r && empty_o);

  a_r3_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o <= CW'(DEPTH)) && !(full_o && empty_o));

  a_r6_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_mask_i |-> !irq_o);

  a_r7_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_r && full_o && !pop_r) |=> (count_o == CW'(DEPTH)));

  a_r7_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(bad_acc));

  a_r8_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_r && !full_o && pop_r && !empty_o) |=> $stable(count_o));

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);
endmodule

bind fifo_svc_irq fsi_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dir_i(dir_i), .svc_mask_i(svc_mask_i),
  .host_wr_i(host_wr_i), .host_rd_i(host_rd_i),
  .per_wr_i(per_wr_i), .per_rd_i(per_rd_i),
  .count_o(count_o), .full_o(full_o), .empty_o(empty_o),
  .irq_o(irq_o), .err_o(err_o), .err_clr_i(err_clr_i)
);

// File: tb/sim_fifo_svc_irq.sv
`timescale 1ns/1ps
module sim_fifo_svc_irq;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       dir_i = 1'b0, svc_mask_i = 1'b0, err_clr_i = 1'b0;
  logic [3:0] thresh_i = 4'd12;
  logic       host_wr_i = 0, host_rd_i = 0, per_wr_i = 0, per_rd_i = 0;
  logic [7:0] host_wdata_i = 0, per_wdata_i = 0;
  logic [7:0] rd_data_o;
  logic [4:0] count_o;
  logic       full_o, empty_o, irq_o, err_o;

  int total = 0, bad = 0;
  logic [7:0] sb_q[$];
  bit m_err = 0;

  always #2.5 clk_i = ~clk_i;

  fifo_svc_irq u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic check_state();
    int n = sb_q.size();
    int e_irq;
    if (svc_mask_i) e_irq = 0;
    else if (dir_i) e_irq = (n + thresh_i >= 16) ? 1 : 0;
    else            e_irq = (n <= thresh_i) ? 1 : 0;
    chk("R3 count", count_o, n);
    chk("R3 full", full_o, n == 16);
    chk("R3 empty", empty_o, n == 0);
    chk(svc_mask_i ? "R6 irq" : (dir_i ? "R5 irq" : "R4 irq"), irq_o, e_irq);
    chk("R7/R9 err", err_o, m_err);
  endtask

  // driver plus scoreboard monitor for one cycle
  task automatic xfer(input bit hw, input bit pw, input bit hr, input bit pr,
                      input logic [7:0] d, input bit clr);
    int  sz;
    bit  push_r, pop_r, ill;
    @(negedge clk_i);
    host_wr_i = hw; per_wr_i = pw; host_rd_i = hr; per_rd_i = pr;
    host_wdata_i = d; per_wdata_i = d; err_clr_i = clr;
    #0.5;
    sz     = sb_q.size();
    push_r = dir_i ? pw : hw;
    pop_r  = dir_i ? hr : pr;
    ill    = (push_r && sz == 16) || (pop_r && sz == 0);
    if (pop_r && sz != 0) chk("R1 data", rd_data_o, sb_q.pop_front());
    if (push_r && sz != 16) sb_q.push_back(d);
    if (ill) m_err = 1; else if (clr) m_err = 0;
    @(posedge clk_i);
    #1;
    host_wr_i = 0; per_wr_i = 0; host_rd_i = 0; per_rd_i = 0; err_clr_i = 0;
    check_state();
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #12 rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    chk("R10 count", count_o, 0);
    chk("R10 empty", empty_o, 1);
    chk("R10 full", full_o, 0);
    chk("R10 err", err_o, 0);
    chk("R4 irq at reset", irq_o, 1);

    // forward fill, thresh 12: R4 edges at 12/13
    for (int i = 0; i < 16; i++) xfer(1, 0, 0, 0, 8'(8'h30 + i), 0);
    // R7 overflow dropped
    xfer(1, 0, 0, 0, 8'hEE, 0);
    // R9 sticky over idle cycles
    xfer(0, 0, 0, 0, 8'h00, 0);
    chk("R9 still set", err_o, 1);
    xfer(0, 0, 0, 0, 8'h00, 1);
    chk("R9 cleared", err_o, 0);
    // R2 inactive-side strobes ignored in forward mode
    xfer(0, 1, 1, 0, 8'h55, 0);
    chk("R2 count kept", count_o, 16);
    chk("R2 no err", err_o, 0);
    // R6 mask
    thresh_i = 4'd15;
    svc_mask_i = 1;
    xfer(0, 0, 0, 1, 8'h00, 0);
    svc_mask_i = 0;
    // drain via peripheral, R1 order
    for (int i = 0; i < 15; i++) xfer(0, 0, 0, 1, 8'h00, 0);
    // R7 underflow, R9 set wins over clear
    xfer(0, 0, 0, 1, 8'h00, 1);
    chk("R9 set wins", err_o, 1);
    xfer(0, 0, 0, 0, 8'h00, 1);
    // R8 simultaneous push/pop
    for (int i = 0; i < 5; i++) xfer(1, 0, 0, 0, 8'(8'hA0 + i), 0);
    for (int i = 0; i < 4; i++) begin
      xfer(1, 0, 0, 1, 8'(8'hB0 + i), 0);
      chk("R8 count", count_o, 5);
    end
    // R4 threshold sweep at count 5
    for (int t = 0; t < 16; t++) begin
      thresh_i = 4'(t);
      #0.5 chk("R4 sweep", irq_o, (5 <= t) ? 1 : 0);
    end
    for (int i = 0; i < 5; i++) xfer(0, 0, 0, 1, 8'h00, 0);

    // reverse mode, thresh 4: R5 edges at 11/12
    dir_i = 1; thresh_i = 4'd4;
    for (int i = 0; i < 16; i++) xfer(0, 1, 0, 0, 8'(8'hC0 + i), 0);
    // R2 host write / peripheral read ignored in reverse
    xfer(1, 0, 0, 1, 8'h77, 0);
    chk("R2 rev ignored", count_o, 16);
    thresh_i = 4'd0;
    xfer(0, 0, 1, 0, 8'h00, 0);
    chk("R5 thresh0 below full", irq_o, 0);
    for (int i = 0; i < 15; i++) xfer(0, 0, 1, 0, 8'h00, 0);
    xfer(0, 0, 1, 0, 8'h00, 1);
    chk("R7 rev underflow", err_o, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule